// File: doc/BRIEF.md
# Power domain sequencing controller

This block brings a small set of independent power domains up and down on command. Every domain has its own register bank on a simple memory-mapped bus. Software writes a command word to a domain's bank. A per-domain sequencer then drives that domain's power-switch enable, isolation enable, clock enable and reset release in a fixed order. Programmable cycle delays separate the switch and isolation steps.

Software starts a transition and then polls the domain's status word. The word carries a busy flag, the settled domain state and a sticky completion flag that software clears by writing one to it. Two read-only words show the live gate outputs and the power-switch enable together with its acknowledge input. The analog switches, clock trees and reset fabric sit outside the block. They appear here only as enable outputs and the acknowledge inputs.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Domain d owns the 128-byte window starting at address d*0x80. Offset 0x14 holds the switch delay, 0x18 the off delay and 0x1c the on delay. Each delay is DLY_W bits wide and reads back what was written, truncated to DLY_W bits. Other unmapped offsets read 0. A window above the last domain reads 0, and writes to it change nothing.
- R2: After reset, every domain has its switch enable at 0, isolation at 1, clock enable at 0 and reset release at 0. The status word (offset 0x24) then reads 0x00020000, which is state off and neither busy nor done.
- R3: Writing 1 to offset 0x20 of an off, idle domain starts power-up. With switch delay S and on delay N, counting from the edge that captures the write: the switch enable rises on that edge, isolation drops S+N+2 edges later, the clock enable rises one edge after that, and reset is released one edge after the clock.
- R4: Writing 2 to offset 0x20 of an on, idle domain starts power-down. With off delay F, counting from the capture edge: reset is asserted on that edge, the clock enable drops one edge later, isolation rises two edges later, and the switch enable drops F+S+4 edges later.
- R5: Status bit 3 (busy) is set from the capture edge until the final step. Bits 17:16 hold 2 (off) or 1 (on) and keep the old state while busy. On the final step's edge, busy clears, the state field flips and bit 1 (done) is set.
- R6: Writing the status word with bit 1 set clears done. Writing it with bit 1 clear leaves done unchanged.
- R7: A command has no effect in three cases: it is written while busy, its value is neither 1 nor 2, or it asks for the state the domain already has. No output changes, busy stays clear and done is not set.
- R8: The gate-status word (offset 0x30) shows reset release in bit 0, clock enable in bit 1 and isolation in bit 2. The switch-status word (offset 0x34) shows the switch enable in bit 0 and the domain's acknowledge input in bit 1.
- R9: A domain that is idle and receives no command keeps all four outputs unchanged, whatever happens in the other domains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address: domain index above bit 7, offset in bits 6:0 |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| pd_sw_ack | input | NUM_DOM | Power-switch acknowledge per domain, reported only |
| pd_sw_en | output | NUM_DOM | Power-switch enable per domain |
| pd_iso_en | output | NUM_DOM | Isolation enable per domain, 1 = isolated |
| pd_clk_en | output | NUM_DOM | Clock enable per domain |
| pd_rst_n | output | NUM_DOM | Reset release per domain, 0 = held in reset |

## Verification
The assertions check the electrical ordering on every cycle. Isolation is always on while the switch is off, the clock never runs while isolated, and reset is never released without a clock. They also check that busy falls only together with a state flip, that done follows completion and the write-one-to-clear rule, that same-state commands start nothing, and that idle domains hold still. The exact edge on which each output moves, as a function of the three delays, can only be shown by the bench's scoreboard. The same holds for the register address map, the delay truncation and the values read from the status words.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int OFS_W = 7;

    localparam logic [OFS_W-1:0] OFS_SW_DLY  = 7'h14;
    localparam logic [OFS_W-1:0] OFS_OFF_DLY = 7'h18;
    localparam logic [OFS_W-1:0] OFS_ON_DLY  = 7'h1C;
    localparam logic [OFS_W-1:0] OFS_CMD     = 7'h20;
    localparam logic [OFS_W-1:0] OFS_STAT    = 7'h24;
    localparam logic [OFS_W-1:0] OFS_GATES   = 7'h30;
    localparam logic [OFS_W-1:0] OFS_SWSTAT  = 7'h34;

    localparam int STAT_DONE_BIT  = 1;
    localparam int STAT_BUSY_BIT  = 3;
    localparam int STAT_STATE_LSB = 16;

    localparam logic [1:0] CODE_ON  = 2'd1;
    localparam logic [1:0] CODE_OFF = 2'd2;

    localparam int CMD_UP   = 1;
    localparam int CMD_DOWN = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_SW,
        ST_UP_ON,
        ST_UP_CLK,
        ST_UP_RST,
        ST_DN_CLK,
        ST_DN_ISO,
        ST_DN_OFF,
        ST_DN_SW
    } seq_st_e;

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_up,
    input  logic             req_down,
    input  logic [DLY_W-1:0] dly_sw,
    input  logic [DLY_W-1:0] dly_on,
    input  logic [DLY_W-1:0] dly_off,
    output logic             busy,
    output logic             is_on,
    output logic             finish,
    output logic             sw_en,
    output logic             iso_en,
    output logic             clk_en,
    output logic             rst_rel
);

    typedef struct packed {
        seq_st_e          st;
        logic [DLY_W-1:0] cnt;
        logic             sw;
        logic             iso;
        logic             ck;
        logic             rls;
        logic             on;
    } fsm_t;

    fsm_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        finish = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_up && !seq_q.on) begin
                    seq_d.sw  = 1'b1;
                    seq_d.cnt = dly_sw;
                    seq_d.st  = ST_UP_SW;
                end else if (req_down && seq_q.on) begin
                    seq_d.rls = 1'b0;
                    seq_d.st  = ST_DN_CLK;
                end
            end
            ST_UP_SW: begin
                if (seq_q.cnt == '0) begin
                    seq_d.cnt = dly_on;
                    seq_d.st  = ST_UP_ON;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_UP_ON: begin
                if (seq_q.cnt == '0) begin
                    seq_d.iso = 1'b0;
                    seq_d.st  = ST_UP_CLK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_UP_CLK: begin
                seq_d.ck = 1'b1;
                seq_d.st = ST_UP_RST;
            end
            ST_UP_RST: begin
                seq_d.rls = 1'b1;
                seq_d.on  = 1'b1;
                seq_d.st  = ST_IDLE;
                finish    = 1'b1;
            end
            ST_DN_CLK: begin
                seq_d.ck = 1'b0;
                seq_d.st = ST_DN_ISO;
            end
            ST_DN_ISO: begin
                seq_d.iso = 1'b1;
                seq_d.cnt = dly_off;
                seq_d.st  = ST_DN_OFF;
            end
            ST_DN_OFF: begin
                if (seq_q.cnt == '0) begin
                    seq_d.cnt = dly_sw;
                    seq_d.st  = ST_DN_SW;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_DN_SW: begin
                if (seq_q.cnt == '0) begin
                    seq_d.sw = 1'b0;
                    seq_d.on = 1'b0;
                    seq_d.st = ST_IDLE;
                    finish   = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, sw: 1'b0, iso: 1'b1,
                       ck: 1'b0, rls: 1'b0, on: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.st != ST_IDLE);
    assign is_on   = seq_q.on;
    assign sw_en   = seq_q.sw;
    assign iso_en  = seq_q.iso;
    assign clk_en  = seq_q.ck;
    assign rst_rel = seq_q.rls;

    p_iso_when_unpowered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> iso_en);

    p_no_clock_while_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> !iso_en);

    p_reset_needs_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rel |-> clk_en);

    p_busy_ends_with_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (is_on != $past(is_on)));

    p_same_state_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_up && !req_down && is_on) |=> !busy);

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             busy,
    input  logic             is_on,
    input  logic             finish,
    input  logic             sw_en,
    input  logic             iso_en,
    input  logic             clk_en,
    input  logic             rst_rel,
    input  logic             sw_ack,
    output logic             req_up,
    output logic             req_down,
    output logic [DLY_W-1:0] dly_sw,
    output logic [DLY_W-1:0] dly_on,
    output logic [DLY_W-1:0] dly_off
);

    typedef struct packed {
        logic [DLY_W-1:0] sw_dly;
        logic [DLY_W-1:0] on_dly;
        logic [DLY_W-1:0] off_dly;
        logic             done;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  stat_wr;

    assign req_up   = wr_en && (ofs == OFS_CMD) && (wdata == DW'(CMD_UP));
    assign req_down = wr_en && (ofs == OFS_CMD) && (wdata == DW'(CMD_DOWN));
    assign stat_wr  = wr_en && (ofs == OFS_STAT);

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (ofs)
                OFS_SW_DLY:  bank_d.sw_dly  = wdata[DLY_W-1:0];
                OFS_ON_DLY:  bank_d.on_dly  = wdata[DLY_W-1:0];
                OFS_OFF_DLY: bank_d.off_dly = wdata[DLY_W-1:0];
                default: ;
            endcase
        end
        if (finish) begin
            bank_d.done = 1'b1;
        end else if (stat_wr && wdata[STAT_DONE_BIT]) begin
            bank_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_SW_DLY:  rdata[DLY_W-1:0] = bank_q.sw_dly;
            OFS_ON_DLY:  rdata[DLY_W-1:0] = bank_q.on_dly;
            OFS_OFF_DLY: rdata[DLY_W-1:0] = bank_q.off_dly;
            OFS_STAT: begin
                rdata[STAT_DONE_BIT] = bank_q.done;
                rdata[STAT_BUSY_BIT] = busy;
                rdata[STAT_STATE_LSB+1:STAT_STATE_LSB] = is_on ? CODE_ON : CODE_OFF;
            end
            OFS_GATES: begin
                rdata[0] = rst_rel;
                rdata[1] = clk_en;
                rdata[2] = iso_en;
            end
            OFS_SWSTAT: begin
                rdata[0] = sw_en;
                rdata[1] = sw_ack;
            end
            default: ;
        endcase
    end

    assign dly_sw  = bank_q.sw_dly;
    assign dly_on  = bank_q.on_dly;
    assign dly_off = bank_q.off_dly;

    p_done_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[STAT_DONE_BIT] && !finish) |=> !bank_q.done);

    p_done_after_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (bank_q.done && !busy));

    p_done_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.done && !(stat_wr && wdata[STAT_DONE_BIT])) |=> bank_q.done);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 9,
    parameter int DW      = 32,
    parameter int DLY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_DOM-1:0] pd_sw_ack,
    output logic [NUM_DOM-1:0] pd_sw_en,
    output logic [NUM_DOM-1:0] pd_iso_en,
    output logic [NUM_DOM-1:0] pd_clk_en,
    output logic [NUM_DOM-1:0] pd_rst_n
);

    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0]   dom_idx;
    logic [OFS_W-1:0]   dom_ofs;
    logic [NUM_DOM-1:0] dom_sel;
    logic [NUM_DOM-1:0] dom_busy;
    logic [DW-1:0]      dom_rd [NUM_DOM];

    assign dom_idx = bus_addr[ADDR_W-1:OFS_W];
    assign dom_ofs = bus_addr[OFS_W-1:0];

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic             up, down, busy, on, fin;
        logic [DLY_W-1:0] dsw, don, doff;

        assign dom_sel[d]  = (dom_idx == IDX_W'(d));
        assign dom_busy[d] = busy;

        pwr_seq_regs #(.DW(DW), .DLY_W(DLY_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_we && dom_sel[d]),
            .ofs      (dom_ofs),
            .wdata    (bus_wdata),
            .rdata    (dom_rd[d]),
            .busy     (busy),
            .is_on    (on),
            .finish   (fin),
            .sw_en    (pd_sw_en[d]),
            .iso_en   (pd_iso_en[d]),
            .clk_en   (pd_clk_en[d]),
            .rst_rel  (pd_rst_n[d]),
            .sw_ack   (pd_sw_ack[d]),
            .req_up   (up),
            .req_down (down),
            .dly_sw   (dsw),
            .dly_on   (don),
            .dly_off  (doff)
        );

        pwr_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_up   (up),
            .req_down (down),
            .dly_sw   (dsw),
            .dly_on   (don),
            .dly_off  (doff),
            .busy     (busy),
            .is_on    (on),
            .finish   (fin),
            .sw_en    (pd_sw_en[d]),
            .iso_en   (pd_iso_en[d]),
            .clk_en   (pd_clk_en[d]),
            .rst_rel  (pd_rst_n[d])
        );

        p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!dom_busy[d] && !(bus_we && dom_sel[d])) |=>
                ($stable(pd_sw_en[d]) && $stable(pd_iso_en[d]) &&
                 $stable(pd_clk_en[d]) && $stable(pd_rst_n[d])));
    end

    always_comb begin
        bus_rdata = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (dom_sel[d]) begin
                bus_rdata = dom_rd[d];
            end
        end
    end

endmodule

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;

    localparam int ND = 3;
    localparam int VW = 4 * ND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [ND-1:0] pd_sw_ack = '0;
    logic [ND-1:0] pd_sw_en, pd_iso_en, pd_clk_en, pd_rst_n;

    pwr_seq_ctrl u_pwr_seq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pd_sw_ack (pd_sw_ack),
        .pd_sw_en  (pd_sw_en),
        .pd_iso_en (pd_iso_en),
        .pd_clk_en (pd_clk_en),
        .pd_rst_n  (pd_rst_n)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [VW-1:0] vec;
        int            at;
        string         req;
    } exp_t;

    exp_t sbq[$];

    logic [ND-1:0] m_sw  = '0;
    logic [ND-1:0] m_iso = '1;
    logic [ND-1:0] m_clk = '0;
    logic [ND-1:0] m_rst = '0;

    logic          mon_en = 1'b0;
    logic [VW-1:0] prev_vec;

    function automatic logic [VW-1:0] model_vec();
        return {m_sw, m_iso, m_clk, m_rst};
    endfunction

    task automatic push_exp(int at, string req);
        exp_t e;
        e.vec = model_vec();
        e.at  = at;
        e.req = req;
        sbq.push_back(e);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: every change on the gate outputs must match the next queued item
    always @(negedge clk) begin
        if (mon_en) begin
            logic [VW-1:0] cur;
            cur = {pd_sw_en, pd_iso_en, pd_clk_en, pd_rst_n};
            if (cur !== prev_vec) begin
                n_chk++;
                if (sbq.size() == 0) begin
                    n_fail++;
                    $display("FAIL R7/R9 unexpected output change actual=%h expected=%h at cycle %0d",
                             cur, prev_vec, cyc);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (cur !== e.vec || cyc != e.at) begin
                        n_fail++;
                        $display("FAIL %s actual=%h@%0d expected=%h@%0d",
                                 e.req, cur, cyc, e.vec, e.at);
                    end
                end
                prev_vec = cur;
            end
        end
    end

    // call right after a negedge: drive for one cycle
    task automatic wr_now(logic [8:0] a, logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic bus_read(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic logic [8:0] ra(int d, int ofs);
        return 9'(d * 128 + ofs);
    endfunction

    task automatic do_on(int d, int ds, int don, output int cap);
        @(negedge clk);
        cap = cyc + 1;
        m_sw[d] = 1'b1;  push_exp(cap, "R3 switch on");
        m_iso[d] = 1'b0; push_exp(cap + ds + don + 2, "R3 isolation off");
        m_clk[d] = 1'b1; push_exp(cap + ds + don + 3, "R3 clock on");
        m_rst[d] = 1'b1; push_exp(cap + ds + don + 4, "R3 reset release");
        wr_now(ra(d, 'h20), 32'd1);
    endtask

    task automatic do_off(int d, int ds, int doff, output int cap);
        @(negedge clk);
        cap = cyc + 1;
        m_rst[d] = 1'b0; push_exp(cap, "R4 reset assert");
        m_clk[d] = 1'b0; push_exp(cap + 1, "R4 clock off");
        m_iso[d] = 1'b1; push_exp(cap + 2, "R4 isolation on");
        m_sw[d] = 1'b0;  push_exp(cap + doff + ds + 4, "R4 switch off");
        wr_now(ra(d, 'h20), 32'd2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        report();
        $finish;
    end

    initial begin
        logic [31:0] r;
        int cap;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        prev_vec = {pd_sw_en, pd_iso_en, pd_clk_en, pd_rst_n};
        mon_en = 1'b1;

        // R2: reset state
        check("R2 outputs", 32'(prev_vec), 32'(model_vec()));
        for (int d = 0; d < ND; d++) begin
            bus_read(ra(d, 'h24), r);
            check("R2 status", r, 32'h0002_0000);
            bus_read(ra(d, 'h30), r);
            check("R8 gates after reset", r, 32'h4);
        end

        // R1: map, truncation, unmapped window
        bus_write(ra(1, 'h14), 32'hA5);
        bus_read(ra(1, 'h14), r);
        check("R1 delay readback", r, 32'hA5);
        bus_write(ra(1, 'h18), 32'h1FF);
        bus_read(ra(1, 'h18), r);
        check("R1 delay truncation", r, 32'hFF);
        bus_read(ra(0, 'h14), r);
        check("R1 other domain untouched", r, 32'h0);
        bus_read(ra(1, 'h00), r);
        check("R1 unmapped offset", r, 32'h0);
        bus_write(ra(3, 'h14), 32'h9);
        bus_read(ra(3, 'h14), r);
        check("R1 window above last domain", r, 32'h0);
        bus_read(ra(1, 'h14), r);
        check("R1 write above last domain ignored", r, 32'hA5);
        bus_write(ra(1, 'h14), 32'h0);

        // R3/R5: dom0 up with S=3, N=2
        bus_write(ra(0, 'h14), 32'd3);
        bus_write(ra(0, 'h1C), 32'd2);
        bus_write(ra(0, 'h18), 32'd4);
        do_on(0, 3, 2, cap);
        bus_read(ra(0, 'h24), r);
        check("R5 busy during power-up", r, 32'h0002_0008);
        wait_until(cap + 3 + 2 + 4);
        bus_read(ra(0, 'h24), r);
        check("R5 done and on after power-up", r, 32'h0001_0002);
        bus_read(ra(0, 'h30), r);
        check("R8 gates when on", r, 32'h3);
        pd_sw_ack = 3'b001;
        bus_read(ra(0, 'h34), r);
        check("R8 switch status with ack", r, 32'h3);
        bus_read(ra(1, 'h34), r);
        check("R8 switch status off", r, 32'h0);
        pd_sw_ack = 3'b011;
        bus_read(ra(1, 'h34), r);
        check("R8 ack only", r, 32'h2);

        // R6: write-one-to-clear
        bus_write(ra(0, 'h24), 32'h0001_0000);
        bus_read(ra(0, 'h24), r);
        check("R6 write without bit 1 keeps done", r, 32'h0001_0002);
        bus_write(ra(0, 'h24), 32'h0001_0002);
        bus_read(ra(0, 'h24), r);
        check("R6 write bit 1 clears done", r, 32'h0001_0000);

        // R7: same-state and bad codes
        bus_write(ra(0, 'h20), 32'd1);
        bus_read(ra(0, 'h24), r);
        check("R7 on while on ignored", r, 32'h0001_0000);
        bus_write(ra(1, 'h20), 32'd3);
        bus_read(ra(1, 'h24), r);
        check("R7 bad code ignored", r, 32'h0002_0000);
        bus_write(ra(1, 'h20), 32'h102);
        bus_read(ra(1, 'h24), r);
        check("R7 wide bad code ignored", r, 32'h0002_0000);
        bus_write(ra(1, 'h20), 32'd2);
        bus_read(ra(1, 'h24), r);
        check("R7 off while off ignored", r, 32'h0002_0000);

        // R4: dom0 down with F=4, S=3; commands while busy ignored
        do_off(0, 3, 4, cap);
        bus_read(ra(0, 'h24), r);
        check("R5 busy during power-down keeps state", r, 32'h0001_0008);
        bus_write(ra(0, 'h20), 32'd1);
        bus_write(ra(0, 'h20), 32'd2);
        wait_until(cap + 4 + 3 + 4);
        bus_read(ra(0, 'h24), r);
        check("R4 done and off after power-down", r, 32'h0002_0002);
        bus_read(ra(0, 'h30), r);
        check("R8 gates when off", r, 32'h4);
        bus_write(ra(0, 'h24), 32'h2);

        // R3/R4 zero delays on dom2
        do_on(2, 0, 0, cap);
        wait_until(cap + 4);
        bus_read(ra(2, 'h24), r);
        check("R3 zero-delay power-up done", r, 32'h0001_0002);
        do_off(2, 0, 0, cap);
        wait_until(cap + 4);
        bus_read(ra(2, 'h24), r);
        check("R4 zero-delay power-down done", r, 32'h0002_0002);

        repeat (10) @(negedge clk);
        check("R9 no missing output changes", 32'(sbq.size()), 32'd0);
        check("R9 final outputs", 32'({pd_sw_en, pd_iso_en, pd_clk_en, pd_rst_n}),
              32'(model_vec()));

        report();
        $finish;
    end

endmodule